// File: doc/BRIEF.md
# Link Reset Sequencer

This block runs the reset procedure of a link's transport layer and data-link layer without software in the loop. It is the only master on a simple register bus. That bus has a request/acknowledge handshake, an address, a select between 32-bit and 64-bit transfers, write data and read data. A one-cycle `start_i` pulse launches the procedure. The block then issues a fixed series of writes and read-modify-write cycles to a handful of control registers. After each change to the transport reset bits it waits on a two-bit fence status field.

The procedure has four ordered phases:

1. Program the arbitration priority and assert transport reset.
2. Pulse the data-link reset bits and enable the data link.
3. Release transport reset in two steps.
4. Load the transmit header credits.

Each fence wait re-reads the status register until its top field shows the code for that phase. If the code does not appear within `POLL_MAX` reads, the run stops with `fail_o` set. `done_o` and `fail_o` keep their values until the next start.

Register addresses are parameters of the block. In the text below, bit numbers are little-endian, with bit 0 as the least significant bit.

Top module: `link_rst_seq`

## Requirements
- R1: After reset, `req_o`, `busy_o`, `done_o` and `fail_o` are low, and no bus request is issued until `start_i` is seen.
- R2: A successful run issues exactly eight writes, to the addresses PRI, MISC, DLC, DLC, DLCFG, MISC, MISC and CRED in that order. Every MISC or DLC write is preceded by a read of the same register.
- R3: The priority write is 64-bit. Bits 63:62 hold `dev_idx_i` modulo 3, sampled at start, and all other bits are zero.
- R4: The first MISC write is the value read with bits 55 and 54 set. The second MISC write is the value read with only bit 54 cleared. The third MISC write is the value read with bits 55 and 54 cleared. All other bits are preserved.
- R5: DLC and DLCFG transfers are 32-bit, and the upper 32 bits of their write data are zero. The first DLC write sets bits 31:30 of the value read. The second DLC write clears them. Other bits are preserved in both. DLCFG is written with 0x80000000.
- R6: After each MISC write, the block reads FENCE until bits 63:62 equal 2'b11, then 2'b10, then 2'b00 for the three writes in turn. Bits 61:0 of FENCE are ignored.
- R7: A fence wait that sees no match in `POLL_MAX` reads ends the run with `fail_o` high, `done_o` low and no further bus traffic. A match on read number `POLL_MAX` still succeeds.
- R8: The last write puts `CRED_VAL` (default 0x0200000000000000) into CRED. Its acknowledge raises `done_o`.
- R9: Once `req_o` is raised, it stays high with address, data, direction and size unchanged until the cycle in which `ack_i` is high.
- R10: `start_i` has no effect while `busy_o` is high. `done_o` and `fail_o` are low while busy, hold their value while idle, and both clear when a new run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the sequence (used only while idle) |
| dev_idx_i | input | IDX_W | Device index, source of the priority field |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus write (1) or read (0) |
| wide_o | output | 1 | Transfer size: 1 = 64-bit, 0 = 32-bit on bits 31:0 |
| addr_o | output | AW | Bus address |
| wdata_o | output | 64 | Bus write data |
| ack_i | input | 1 | Bus acknowledge, completes the current request |
| rdata_i | input | 64 | Bus read data, valid with `ack_i` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run completed successfully |
| fail_o | output | 1 | Last run ended on a fence timeout |

## Verification
The hardest behaviour to reach from the ports is the edge of the poll window. A fence code that matches exactly on read `POLL_MAX` must still pass, and one that never matches within `POLL_MAX` reads must fail in each of the three phases. The bench's bus responder models the fence field as a lagged copy of the transport reset bits last written to MISC. A programmable number of stale reads per phase lets directed runs place the match on read `POLL_MAX`, or just past it, in any phase. Random acknowledge delays, random junk in the unused read bits and random register contents run alongside these directed runs.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PRI_WR,
    S_MISC_RD0, S_MISC_WR0, S_POLL0,
    S_DLC_RD0,  S_DLC_WR0,  S_DLC_RD1, S_DLC_WR1, S_DLCFG_WR,
    S_MISC_RD1, S_MISC_WR1, S_POLL1,
    S_MISC_RD2, S_MISC_WR2, S_POLL2,
    S_CRED_WR
  } rsq_state_e;

  localparam logic [1:0] FENCE_SET  = 2'b11;
  localparam logic [1:0] FENCE_HALF = 2'b10;
  localparam logic [1:0] FENCE_OFF  = 2'b00;

  // big-endian bit numbering to little-endian masks
  function automatic logic [63:0] be64(input int n);
    be64 = 64'd1 << (63 - n);
  endfunction

  function automatic logic [31:0] be32(input int n);
    be32 = 32'd1 << (31 - n);
  endfunction

endpackage

// File: rtl/rsq_bus_master.sv
module rsq_bus_master #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          we_i,
  input  logic          wide_i,
  input  logic [AW-1:0] addr_i,
  input  logic [63:0]   wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic          wide_o,
  output logic [AW-1:0] addr_o,
  output logic [63:0]   wdata_o,
  input  logic          ack_i,
  output logic          xfer_done_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      wide_o  <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (issue_i) begin
      req_o   <= 1'b1;
      we_o    <= we_i;
      wide_o  <= wide_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end else if (req_o && ack_i) begin
      req_o   <= 1'b0;
    end
  end

  assign xfer_done_o = req_o & ack_i;

endmodule

// File: rtl/rsq_poll_timer.sv
module rsq_poll_timer #(
  parameter int POLL_MAX = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);

  localparam int CW = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // current read is the last one allowed
  assign last_o = (cnt_q == CW'(POLL_MAX - 1));

endmodule

// File: rtl/rsq_seq_fsm.sv
module rsq_seq_fsm
  import rsq_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          IDX_W      = 4,
  parameter logic [AW-1:0] PRI_ADDR   = 8'h10,
  parameter logic [AW-1:0] MISC_ADDR  = 8'h20,
  parameter logic [AW-1:0] FENCE_ADDR = 8'h28,
  parameter logic [AW-1:0] DLC_ADDR   = 8'h30,
  parameter logic [AW-1:0] DLCFG_ADDR = 8'h34,
  parameter logic [AW-1:0] CRED_ADDR  = 8'h40,
  parameter logic [63:0]   CRED_VAL   = 64'h0200_0000_0000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] dev_idx_i,
  input  logic             xfer_done_i,
  input  logic [63:0]      rdata_i,
  input  logic             poll_last_i,
  output logic             issue_o,
  output logic             op_we_o,
  output logic             op_wide_o,
  output logic [AW-1:0]    op_addr_o,
  output logic [63:0]      op_wdata_o,
  output logic             poll_clr_o,
  output logic             poll_tick_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam logic [63:0] NTL_BOTH  = be64(8) | be64(9);
  localparam logic [63:0] NTL_B9    = be64(9);
  localparam logic [31:0] DL_BOTH   = be32(0) | be32(1);
  localparam logic [31:0] DLCFG_VAL = be32(0);

  rsq_state_e       state_q, step_next;
  logic             pend_q;
  logic [63:0]      rd_q;
  logic [IDX_W-1:0] dev_q;
  logic             done_q, fail_q;
  logic             is_poll, match;
  logic [1:0]       poll_code;
  logic [IDX_W-1:0] dev_rem;

  assign dev_rem = dev_q % IDX_W'(3);

  always_comb begin
    step_next = S_IDLE;
    is_poll   = 1'b0;
    poll_code = FENCE_OFF;
    case (state_q)
      S_PRI_WR:   step_next = S_MISC_RD0;
      S_MISC_RD0: step_next = S_MISC_WR0;
      S_MISC_WR0: step_next = S_POLL0;
      S_POLL0:    begin step_next = S_DLC_RD0;  is_poll = 1'b1; poll_code = FENCE_SET;  end
      S_DLC_RD0:  step_next = S_DLC_WR0;
      S_DLC_WR0:  step_next = S_DLC_RD1;
      S_DLC_RD1:  step_next = S_DLC_WR1;
      S_DLC_WR1:  step_next = S_DLCFG_WR;
      S_DLCFG_WR: step_next = S_MISC_RD1;
      S_MISC_RD1: step_next = S_MISC_WR1;
      S_MISC_WR1: step_next = S_POLL1;
      S_POLL1:    begin step_next = S_MISC_RD2; is_poll = 1'b1; poll_code = FENCE_HALF; end
      S_MISC_RD2: step_next = S_MISC_WR2;
      S_MISC_WR2: step_next = S_POLL2;
      S_POLL2:    begin step_next = S_CRED_WR;  is_poll = 1'b1; poll_code = FENCE_OFF;  end
      default:    step_next = S_IDLE;
    endcase
  end

  always_comb begin
    op_we_o    = 1'b0;
    op_wide_o  = 1'b1;
    op_addr_o  = MISC_ADDR;
    op_wdata_o = '0;
    case (state_q)
      S_PRI_WR: begin
        op_we_o    = 1'b1;
        op_addr_o  = PRI_ADDR;
        op_wdata_o = {dev_rem[1:0], 62'd0};
      end
      S_MISC_WR0: begin op_we_o = 1'b1; op_wdata_o = rd_q | NTL_BOTH;  end
      S_MISC_WR1: begin op_we_o = 1'b1; op_wdata_o = rd_q & ~NTL_B9;   end
      S_MISC_WR2: begin op_we_o = 1'b1; op_wdata_o = rd_q & ~NTL_BOTH; end
      S_POLL0, S_POLL1, S_POLL2: op_addr_o = FENCE_ADDR;
      S_DLC_RD0, S_DLC_RD1: begin op_wide_o = 1'b0; op_addr_o = DLC_ADDR; end
      S_DLC_WR0: begin
        op_we_o = 1'b1; op_wide_o = 1'b0; op_addr_o = DLC_ADDR;
        op_wdata_o = {32'd0, rd_q[31:0] | DL_BOTH};
      end
      S_DLC_WR1: begin
        op_we_o = 1'b1; op_wide_o = 1'b0; op_addr_o = DLC_ADDR;
        op_wdata_o = {32'd0, rd_q[31:0] & ~DL_BOTH};
      end
      S_DLCFG_WR: begin
        op_we_o = 1'b1; op_wide_o = 1'b0; op_addr_o = DLCFG_ADDR;
        op_wdata_o = {32'd0, DLCFG_VAL};
      end
      S_CRED_WR: begin
        op_we_o = 1'b1; op_addr_o = CRED_ADDR; op_wdata_o = CRED_VAL;
      end
      default: ;
    endcase
  end

  assign match       = (rdata_i[63:62] == poll_code);
  assign issue_o     = (state_q != S_IDLE) && !pend_q;
  assign poll_clr_o  = !is_poll;
  assign poll_tick_o = is_poll && xfer_done_i && !match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
      rd_q    <= '0;
      dev_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (state_q == S_IDLE) begin
      if (start_i) begin
        state_q <= S_PRI_WR;
        pend_q  <= 1'b0;
        dev_q   <= dev_idx_i;
        done_q  <= 1'b0;
        fail_q  <= 1'b0;
      end
    end else if (xfer_done_i) begin
      pend_q <= 1'b0;
      rd_q   <= op_wide_o ? rdata_i : {32'd0, rdata_i[31:0]};
      if (is_poll && !match) begin
        if (poll_last_i) begin
          state_q <= S_IDLE;
          fail_q  <= 1'b1;
        end
      end else begin
        state_q <= step_next;
        if (state_q == S_CRED_WR) done_q <= 1'b1;
      end
    end else if (issue_o) begin
      pend_q <= 1'b1;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;

endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq #(
  parameter int            AW         = 8,
  parameter int            IDX_W      = 4,
  parameter int            POLL_MAX   = 4096,
  parameter logic [AW-1:0] PRI_ADDR   = 8'h10,
  parameter logic [AW-1:0] MISC_ADDR  = 8'h20,
  parameter logic [AW-1:0] FENCE_ADDR = 8'h28,
  parameter logic [AW-1:0] DLC_ADDR   = 8'h30,
  parameter logic [AW-1:0] DLCFG_ADDR = 8'h34,
  parameter logic [AW-1:0] CRED_ADDR  = 8'h40,
  parameter logic [63:0]   CRED_VAL   = 64'h0200_0000_0000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] dev_idx_i,
  output logic             req_o,
  output logic             we_o,
  output logic             wide_o,
  output logic [AW-1:0]    addr_o,
  output logic [63:0]      wdata_o,
  input  logic             ack_i,
  input  logic [63:0]      rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  logic          issue, op_we, op_wide, xfer_done;
  logic [AW-1:0] op_addr;
  logic [63:0]   op_wdata;
  logic          poll_clr, poll_tick, poll_last;

  rsq_seq_fsm #(
    .AW(AW), .IDX_W(IDX_W),
    .PRI_ADDR(PRI_ADDR), .MISC_ADDR(MISC_ADDR), .FENCE_ADDR(FENCE_ADDR),
    .DLC_ADDR(DLC_ADDR), .DLCFG_ADDR(DLCFG_ADDR), .CRED_ADDR(CRED_ADDR),
    .CRED_VAL(CRED_VAL)
  ) i_fsm (
    .clk_i, .rst_ni, .start_i, .dev_idx_i,
    .xfer_done_i (xfer_done),
    .rdata_i,
    .poll_last_i (poll_last),
    .issue_o     (issue),
    .op_we_o     (op_we),
    .op_wide_o   (op_wide),
    .op_addr_o   (op_addr),
    .op_wdata_o  (op_wdata),
    .poll_clr_o  (poll_clr),
    .poll_tick_o (poll_tick),
    .busy_o, .done_o, .fail_o
  );

  rsq_bus_master #(.AW(AW)) i_bus (
    .clk_i, .rst_ni,
    .issue_i (issue),
    .we_i    (op_we),
    .wide_i  (op_wide),
    .addr_i  (op_addr),
    .wdata_i (op_wdata),
    .req_o, .we_o, .wide_o, .addr_o, .wdata_o,
    .ack_i,
    .xfer_done_o (xfer_done)
  );

  rsq_poll_timer #(.POLL_MAX(POLL_MAX)) i_poll (
    .clk_i, .rst_ni,
    .clr_i  (poll_clr),
    .tick_i (poll_tick),
    .last_o (poll_last)
  );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] CRED_ADDR = 8'h40,
  parameter logic [63:0]   CRED_VAL  = 64'h0200_0000_0000_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          req_o,
  input logic          we_o,
  input logic          wide_o,
  input logic [AW-1:0] addr_o,
  input logic [63:0]   wdata_o,
  input logic          ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o
);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(wdata_o)
                        && $stable(we_o) && $stable(wide_o)); // R9

  AST_NARROW_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o && !wide_o |-> wdata_o[63:32] == 32'd0); // R5

  AST_CRED_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o && addr_o == CRED_ADDR |-> wdata_o == CRED_VAL); // R8

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)); // R7

  AST_BUSY_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o && !fail_o); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(done_o) && $stable(fail_o)); // R10

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o); // R1

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(req_o && ack_i && we_o && addr_o == CRED_ADDR)); // R8

endmodule

bind link_rst_seq rsq_checker #(
  .AW(AW), .CRED_ADDR(CRED_ADDR), .CRED_VAL(CRED_VAL)
) i_rsq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .req_o(req_o), .we_o(we_o), .wide_o(wide_o), .addr_o(addr_o),
  .wdata_o(wdata_o), .ack_i(ack_i), .busy_o(busy_o),
  .done_o(done_o), .fail_o(fail_o)
);

// File: tb/test_link_rst_seq.sv
`timescale 1ns/1ps
module test_link_rst_seq;

  localparam int          AW    = 8;
  localparam int          IDX_W = 4;
  localparam int          PM    = 64;
  localparam logic [7:0]  A_PRI = 8'h10, A_MISC = 8'h20, A_FENCE = 8'h28;
  localparam logic [7:0]  A_DLC = 8'h30, A_DLCFG = 8'h34, A_CRED = 8'h40;
  localparam logic [63:0] CRED  = 64'h0200_0000_0000_0000;
  localparam logic [63:0] M_BOTH = 64'h00C0_0000_0000_0000;
  localparam logic [63:0] M_B54  = 64'h0040_0000_0000_0000;
  localparam logic [31:0] D_BOTH = 32'hC000_0000;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [IDX_W-1:0] dev_idx_i = '0;
  logic req_o, we_o, wide_o, ack_i = 1'b0, busy_o, done_o, fail_o;
  logic [AW-1:0] addr_o;
  logic [63:0] wdata_o, rdata_i = '0;

  always #2.5 clk = ~clk;

  link_rst_seq #(
    .AW(AW), .IDX_W(IDX_W), .POLL_MAX(PM),
    .PRI_ADDR(A_PRI), .MISC_ADDR(A_MISC), .FENCE_ADDR(A_FENCE),
    .DLC_ADDR(A_DLC), .DLCFG_ADDR(A_DLCFG), .CRED_ADDR(A_CRED), .CRED_VAL(CRED)
  ) i_link_rst_seq (
    .clk_i(clk), .rst_ni, .start_i, .dev_idx_i,
    .req_o, .we_o, .wide_o, .addr_o, .wdata_o, .ack_i, .rdata_i,
    .busy_o, .done_o, .fail_o
  );

  int nchk = 0, nerr = 0;

  // bus responder state
  logic [7:0]  wl_a [0:15];
  logic [63:0] wl_d [0:15];
  int wn, misc_wn, f_left, f_reads, hs_bad;
  int lag_arr [1:3];
  logic [1:0]  f_shown, f_target;
  logic [63:0] r_misc, r_pri, r_cred;
  logic [31:0] r_dlc, r_dlcfg;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic bus_xact();
    logic [63:0] j;
    j = {$urandom, $urandom};
    if (we_o) begin
      if (wn < 16) begin wl_a[wn] = addr_o; wl_d[wn] = wdata_o; end
      wn++;
      case (addr_o)
        A_PRI:   r_pri = wdata_o;
        A_MISC: begin
          r_misc = wdata_o;
          misc_wn++;
          f_target = {wdata_o[55], wdata_o[54]};
          f_left = (misc_wn <= 3) ? lag_arr[misc_wn] : 0;
          f_reads = 0;
        end
        A_DLC:   r_dlc = wdata_o[31:0];
        A_DLCFG: r_dlcfg = wdata_o[31:0];
        A_CRED:  r_cred = wdata_o;
        default: ;
      endcase
    end else begin
      case (addr_o)
        A_MISC: rdata_i = r_misc;
        A_DLC:  rdata_i = {j[63:32], r_dlc};
        A_FENCE: begin
          f_reads++;
          if (f_left > 0) f_left--;
          else f_shown = f_target;
          rdata_i = {f_shown, j[61:0]};
        end
        default: rdata_i = j;
      endcase
    end
  endtask

  initial begin : responder
    bit active;
    int wcnt;
    logic [7:0]  ha;
    logic [63:0] hd;
    active = 0; wcnt = 0; ha = '0; hd = '0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        ack_i = 0; active = 0;
      end else if (ack_i) begin
        ack_i = 0; active = 0;
      end else if (req_o) begin
        if (!active) begin
          active = 1; ha = addr_o; hd = wdata_o; wcnt = $urandom % 3;
        end else if (addr_o != ha || wdata_o != hd) hs_bad++;
        if (wcnt == 0) begin bus_xact(); ack_i = 1; end
        else wcnt--;
      end else if (active) hs_bad++;
    end
  end

  task automatic run(input int idx, input int l1, input int l2, input int l3,
                     input int fail_ph, input bit mid_start);
    logic [63:0] misc0, ea [0:7], ed [0:7];
    logic [31:0] dlc0;
    logic [1:0]  rem;
    int nexp, cyc;
    misc0 = {$urandom, $urandom} & ~M_BOTH;
    dlc0  = $urandom;
    r_misc = misc0; r_dlc = dlc0; r_pri = '0; r_cred = '0; r_dlcfg = '0;
    wn = 0; misc_wn = 0; f_left = 0; f_reads = 0; hs_bad = 0;
    f_shown = 2'b00; f_target = 2'b00;
    lag_arr[1] = l1; lag_arr[2] = l2; lag_arr[3] = l3;
    rem = 2'(idx % 3);
    ea[0] = 64'(A_PRI);   ed[0] = {rem, 62'd0};
    ea[1] = 64'(A_MISC);  ed[1] = misc0 | M_BOTH;
    ea[2] = 64'(A_DLC);   ed[2] = {32'd0, dlc0 | D_BOTH};
    ea[3] = 64'(A_DLC);   ed[3] = {32'd0, dlc0 & ~D_BOTH};
    ea[4] = 64'(A_DLCFG); ed[4] = 64'h8000_0000;
    ea[5] = 64'(A_MISC);  ed[5] = (misc0 | M_BOTH) & ~M_B54;
    ea[6] = 64'(A_MISC);  ed[6] = misc0;
    ea[7] = 64'(A_CRED);  ed[7] = CRED;
    nexp = (fail_ph == 0) ? 8 : (fail_ph == 1) ? 2 : (fail_ph == 2) ? 6 : 7;

    @(negedge clk);
    dev_idx_i = IDX_W'(idx); start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o && !done_o && !fail_o, "R10", "flags cleared at start",
        {busy_o, done_o, fail_o}, 3'b100);
    for (cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      start_i = (mid_start && cyc == 5);
      if (done_o || fail_o) break;
    end
    start_i = 0;
    @(negedge clk);
    chk(!req_o, "R7", "bus quiet after end", req_o, 0);

    chk(wn == nexp, (fail_ph != 0) ? "R7" : "R2", "write count", wn, nexp);
    for (int i = 0; i < nexp && i < wn; i++) begin
      chk(wl_a[i] == ea[i][7:0], "R2", $sformatf("write %0d addr", i), wl_a[i], ea[i]);
      chk(wl_d[i] == ed[i],
          (i == 0) ? "R3" : (i == 7) ? "R8" : (i == 1 || i == 5 || i == 6) ? "R4" : "R5",
          $sformatf("write %0d data", i), wl_d[i], ed[i]);
    end
    if (fail_ph != 0) begin
      chk(fail_o && !done_o, "R7", "fail flag", {done_o, fail_o}, 2'b01);
      chk(f_reads == PM, "R7", "reads before timeout", f_reads, PM);
    end else begin
      chk(done_o && !fail_o, "R8", "done flag", {done_o, fail_o}, 2'b10);
      chk(f_reads == l3 + 1, "R6", "final phase poll reads", f_reads, l3 + 1);
    end
    chk(hs_bad == 0, "R9", "request held stable until ack", hs_bad, 0);
    repeat (4) @(negedge clk);
    chk(done_o == (fail_ph == 0) && fail_o == (fail_ph != 0), "R10", "flags held",
        {done_o, fail_o}, {fail_ph == 0, fail_ph != 0});
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    nerr++;
    $display("FAIL R9 watchdog: act=hung exp=complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20171114));
    repeat (3) @(negedge clk);
    chk(!req_o && !busy_o && !done_o && !fail_o, "R1", "reset state",
        {req_o, busy_o, done_o, fail_o}, 4'b0);
    rst_ni = 1;
    repeat (6) @(negedge clk);
    chk(!req_o && !busy_o, "R1", "idle without start", {req_o, busy_o}, 2'b0);

    run(14, 0, 0, 0, 0, 0);
    run(0, 1, 2, 0, 0, 0);
    run(1, 2, 1, 3, 0, 1);          // start while busy ignored
    for (int k = 0; k < 6; k++)
      run($urandom % 16, $urandom % 6, $urandom % 6, $urandom % 6, 0, 1'($urandom % 2));
    run(5, PM - 1, 0, PM - 1, 0, 0); // match on last allowed read
    run(3, PM, 0, 0, 1, 0);          // timeout in each phase
    run(4, 1, PM, 0, 2, 0);
    run(7, 0, 2, PM, 3, 0);
    run(8, 0, PM - 1, 0, 0, 0);      // recovery after fail

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule